// File: doc/BRIEF.md
# Round-Robin Quantum Stream Merger

This block merges several valid/ready streaming inputs onto one output stream. Inputs take turns in round-robin order. The granted input keeps the grant for a fixed number of accepted beats, called the quantum. If the granted input has nothing to send, the grant moves on at once, and the search skips every input that is not asserting valid. Each beat carries data, start and end markers, an empty-symbol count, a channel field and an error field. All of these reach the output unchanged, through a single output register.

Two options change the scheduling and the channel field:

- **Packet-boundary scheduling.** The grant is held until the beat that ends the current packet has been accepted. Beats of different packets therefore never interleave on the output, even when the granted input pauses in the middle of a packet.
- **Source tagging.** The output channel field is widened. The index of the source input is placed in the upper bits, and the input's own channel value sits unchanged in the lower bits.

The block sits in front of any single consumer that has to take traffic from several producers. Backpressure from the consumer reaches only the producer that currently holds the grant.

A channel or error width of zero removes that field. The corresponding input ports then keep a one-bit placeholder that is ignored, and the output drives it to zero.

Top module: `rr_quantum_merge`

## Requirements
- R1: After reset the output valid is low and input 0 holds the grant. With no input valid, the ready vector reads 1 on bit 0 only.
- R2: With every input continuously valid and the output always ready, each input sends exactly QUANTUM beats before the grant passes to the next input, in increasing index order, wrapping from the last index to 0. In the default mode each beat is a one-beat packet.
- R3: The grant skips inputs that are not asserting valid. If only one input is valid, it keeps receiving the grant, even when the search starts at another input.
- R4: With packet-boundary scheduling on, the grant moves only after an end-of-packet beat has been accepted. This holds in two cases: when the quantum expires in mid-packet, and when the granted input pauses in mid-packet while other inputs are valid.
- R5: Data, start-of-packet, end-of-packet, empty and error values appear on the output exactly as they were accepted on the input. Beats leave in the order in which they were accepted.
- R6: With source tagging on, the output channel is {source index, input channel}. The source index occupies the top clog2(N_IN) bits and the input channel occupies the low CH_W bits.
- R7: At most one bit of the ready vector is high, the one for the granted input. That bit equals out_ready OR NOT out_valid.
- R8: While out_valid is high and out_ready is low, every output field holds its value. No beat is lost or duplicated.

Ports tagged [n] are flattened with input i at slice i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Per-input valid |
| in_ready | output | N_IN | Per-input ready, high only for the granted input |
| in_data | input | N_IN*SYM_BITS*SYMS | Per-input beat data [n] |
| in_sop | input | N_IN | Per-input start-of-packet |
| in_eop | input | N_IN | Per-input end-of-packet |
| in_empty | input | N_IN*EMP_W | Per-input empty symbol count [n] |
| in_chan | input | N_IN*CHP | Per-input channel [n] |
| in_err | input | N_IN*ERP | Per-input error [n] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | SYM_BITS*SYMS | Output beat data |
| out_sop | output | 1 | Output start-of-packet |
| out_eop | output | 1 | Output end-of-packet |
| out_empty | output | EMP_W | Output empty count |
| out_chan | output | OCH_W | Output channel, optionally tagged with the source index |
| out_err | output | ERP | Output error |

## Verification
The assertions check four properties on every cycle:

- the ready vector is one-hot or zero;
- the grant stays put after an accepted beat while the quantum has not run out;
- the grant stays put after an accepted beat that does not end a packet in packet mode;
- a stalled output holds steady, and any tag field names an existing input.

The bench scenarios cover what a single cycle cannot show: the full rotation order under sustained traffic, the skipping of idle inputs, the hold across a mid-packet pause, and the end-to-end integrity of every field under irregular backpressure. The integrity check runs through a scoreboard of accepted beats.

// File: rtl/rr_quantum_merge_pkg.sv
package rr_quantum_merge_pkg;
  // bits needed to index n items, never less than one
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // width of a port that may be configured away
  function automatic int min1(input int w);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/rqm_select.sv
module rqm_select #(
  parameter int N_IN  = 4,
  parameter int DW    = 32,
  parameter int EMP_W = 2,
  parameter int CHP   = 4,
  parameter int ERP   = 2,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0]      sel,
  input  logic [N_IN-1:0]       in_valid,
  input  logic [N_IN*DW-1:0]    in_data,
  input  logic [N_IN-1:0]       in_sop,
  input  logic [N_IN-1:0]       in_eop,
  input  logic [N_IN*EMP_W-1:0] in_empty,
  input  logic [N_IN*CHP-1:0]   in_chan,
  input  logic [N_IN*ERP-1:0]   in_err,
  output logic                  s_valid,
  output logic [DW-1:0]         s_data,
  output logic                  s_sop,
  output logic                  s_eop,
  output logic [EMP_W-1:0]      s_empty,
  output logic [CHP-1:0]        s_chan,
  output logic [ERP-1:0]        s_err
);
  always_comb begin
    s_valid = 1'b0;
    s_data  = '0;
    s_sop   = 1'b0;
    s_eop   = 1'b0;
    s_empty = '0;
    s_chan  = '0;
    s_err   = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel == IDX_W'(i)) begin
        s_valid = in_valid[i];
        s_data  = in_data[i*DW +: DW];
        s_sop   = in_sop[i];
        s_eop   = in_eop[i];
        s_empty = in_empty[i*EMP_W +: EMP_W];
        s_chan  = in_chan[i*CHP +: CHP];
        s_err   = in_err[i*ERP +: ERP];
      end
    end
  end
endmodule

// File: rtl/rqm_arbiter.sv
module rqm_arbiter #(
  parameter int N_IN      = 4,
  parameter int IDX_W     = 2,
  parameter int QUANTUM   = 4,
  parameter bit PKT_EN    = 1'b1,
  parameter bit PKT_SCHED = 1'b1,
  localparam int CW       = $clog2(QUANTUM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  in_valid,
  input  logic             sel_valid,
  input  logic             sel_eop,
  input  logic             load_ok,
  output logic [IDX_W-1:0] grant_idx,
  output logic             xfer
);
  logic [CW-1:0]    cnt, cnt_n;
  logic             open_q, open_n;
  logic             expired, rotate;
  logic [IDX_W-1:0] nxt;

  assign xfer = sel_valid && load_ok;

  always_comb begin
    cnt_n = cnt;
    if (xfer && int'(cnt) < QUANTUM) cnt_n = cnt + 1'b1;
    open_n = open_q;
    if (xfer) open_n = PKT_EN ? !sel_eop : 1'b0;
    expired = int'(cnt_n) >= QUANTUM;
    rotate  = (expired || !sel_valid) && !(PKT_SCHED && open_n);
  end

  // next valid input after the current one, current one considered last
  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = grant_idx;
    for (int k = 1; k <= N_IN; k++) begin
      int j;
      j = int'(grant_idx) + k;
      if (j >= N_IN) j = j - N_IN;
      if (!found && in_valid[j]) begin
        nxt   = IDX_W'(j);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_idx <= '0;
      cnt       <= '0;
      open_q    <= 1'b0;
    end else if (rotate) begin
      grant_idx <= nxt;
      cnt       <= '0;
      open_q    <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      open_q <= open_n;
    end
  end

  // R2: an accepted beat inside the quantum never loses the grant
  assert_quantum_hold_R2: assert property (@(posedge clk) disable iff (rst)
    xfer && (int'(cnt) + 1 < QUANTUM) |=> grant_idx == $past(grant_idx));

  // R4: in packet mode a non-final beat keeps the grant
  assert_packet_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (PKT_SCHED && PKT_EN && xfer && !sel_eop) |=> grant_idx == $past(grant_idx));
endmodule

// File: rtl/rqm_outreg.sv
module rqm_outreg #(
  parameter int DW    = 32,
  parameter int EMP_W = 2,
  parameter int OCH_W = 6,
  parameter int ERP   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [DW-1:0]    ld_data,
  input  logic             ld_sop,
  input  logic             ld_eop,
  input  logic [EMP_W-1:0] ld_empty,
  input  logic [OCH_W-1:0] ld_chan,
  input  logic [ERP-1:0]   ld_err,
  output logic             load_ok,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [EMP_W-1:0] out_empty,
  output logic [OCH_W-1:0] out_chan,
  output logic [ERP-1:0]   out_err
);
  assign load_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_empty <= '0;
      out_chan  <= '0;
      out_err   <= '0;
    end else if (load_ok) begin
      out_valid <= ld_valid;
      out_data  <= ld_data;
      out_sop   <= ld_sop;
      out_eop   <= ld_eop;
      out_empty <= ld_empty;
      out_chan  <= ld_chan;
      out_err   <= ld_err;
    end
  end

  // R8: a stalled beat stays put
  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan)
      && $stable(out_sop) && $stable(out_eop) && $stable(out_err) && $stable(out_empty));
endmodule

// File: rtl/rr_quantum_merge.sv
module rr_quantum_merge
  import rr_quantum_merge_pkg::*;
#(
  parameter int N_IN      = 4,
  parameter int SYM_BITS  = 8,
  parameter int SYMS      = 4,
  parameter int CH_W      = 4,
  parameter int ERR_W     = 2,
  parameter int QUANTUM   = 4,
  parameter bit PKT_EN    = 1'b1,
  parameter bit PKT_SCHED = 1'b1,
  parameter bit TAG_SRC   = 1'b1,
  localparam int DW       = SYM_BITS * SYMS,
  localparam int IDX_W    = idx_bits(N_IN),
  localparam int EMP_W    = idx_bits(SYMS),
  localparam int CHP      = min1(CH_W),
  localparam int ERP      = min1(ERR_W),
  localparam int OCH_W    = TAG_SRC ? (IDX_W + CH_W) : CHP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       in_valid,
  output logic [N_IN-1:0]       in_ready,
  input  logic [N_IN*DW-1:0]    in_data,
  input  logic [N_IN-1:0]       in_sop,
  input  logic [N_IN-1:0]       in_eop,
  input  logic [N_IN*EMP_W-1:0] in_empty,
  input  logic [N_IN*CHP-1:0]   in_chan,
  input  logic [N_IN*ERP-1:0]   in_err,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [EMP_W-1:0]      out_empty,
  output logic [OCH_W-1:0]      out_chan,
  output logic [ERP-1:0]        out_err
);
  logic [IDX_W-1:0] grant_idx;
  logic             xfer, load_ok;
  logic             s_valid, s_sop, s_eop;
  logic [DW-1:0]    s_data;
  logic [EMP_W-1:0] s_empty;
  logic [CHP-1:0]   s_chan;
  logic [ERP-1:0]   s_err;
  logic [OCH_W-1:0] ld_chan;
  logic [ERP-1:0]   ld_err;
  logic             ld_sop, ld_eop;
  logic [EMP_W-1:0] ld_empty;

  rqm_select #(.N_IN(N_IN), .DW(DW), .EMP_W(EMP_W), .CHP(CHP), .ERP(ERP), .IDX_W(IDX_W))
  u_select (
    .sel(grant_idx), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .in_empty(in_empty), .in_chan(in_chan), .in_err(in_err),
    .s_valid(s_valid), .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop),
    .s_empty(s_empty), .s_chan(s_chan), .s_err(s_err)
  );

  rqm_arbiter #(.N_IN(N_IN), .IDX_W(IDX_W), .QUANTUM(QUANTUM),
                .PKT_EN(PKT_EN), .PKT_SCHED(PKT_SCHED))
  u_arbiter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel_valid(s_valid),
    .sel_eop(s_eop), .load_ok(load_ok), .grant_idx(grant_idx), .xfer(xfer)
  );

  // packet markers only when packet support is built in
  generate
    if (PKT_EN) begin : g_pkt
      assign ld_sop   = s_sop;
      assign ld_eop   = s_eop;
      assign ld_empty = s_empty;
    end else begin : g_nopkt
      assign ld_sop   = 1'b0;
      assign ld_eop   = 1'b0;
      assign ld_empty = '0;
    end
  endgenerate

  generate
    if (ERR_W > 0) begin : g_err
      assign ld_err = s_err;
    end else begin : g_noerr
      assign ld_err = '0;
    end
  endgenerate

  // channel composition: optional source tag above the input channel
  generate
    if (TAG_SRC && CH_W > 0) begin : g_tag_ch
      assign ld_chan = {grant_idx, s_chan};
    end else if (TAG_SRC) begin : g_tag_only
      assign ld_chan = grant_idx;
    end else if (CH_W > 0) begin : g_ch_only
      assign ld_chan = s_chan;
    end else begin : g_no_ch
      assign ld_chan = '0;
    end
  endgenerate

  rqm_outreg #(.DW(DW), .EMP_W(EMP_W), .OCH_W(OCH_W), .ERP(ERP))
  u_outreg (
    .clk(clk), .rst(rst), .ld_valid(s_valid), .ld_data(s_data), .ld_sop(ld_sop),
    .ld_eop(ld_eop), .ld_empty(ld_empty), .ld_chan(ld_chan), .ld_err(ld_err),
    .load_ok(load_ok), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_empty(out_empty), .out_chan(out_chan), .out_err(out_err)
  );

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_ready
      assign in_ready[i] = load_ok && (grant_idx == IDX_W'(i));
    end
  endgenerate

  // R7: backpressure reaches at most one producer
  assert_one_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  generate
    if (TAG_SRC) begin : g_tag_chk
      // R6: tag always names an existing input
      assert_tag_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(out_chan[OCH_W-1 -: IDX_W]) < N_IN);
    end
  endgenerate
endmodule

// File: tb/test_rr_quantum_merge.sv
`timescale 1ns/1ps
module test_rr_quantum_merge;
  localparam int N   = 3;
  localparam int DW  = 16;
  localparam int CHW = 3;
  localparam int ERW = 2;
  localparam int OCW = 5;

  typedef struct {
    int         src;
    logic [15:0] data;
    logic       sop;
    logic       eop;
    logic       empty;
    logic [2:0] ch;
    logic [1:0] err;
    int         gap;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N-1:0]      in_valid = '0;
  logic [N-1:0]      in_ready;
  logic [N*DW-1:0]   in_data = '0;
  logic [N-1:0]      in_sop = '0, in_eop = '0;
  logic [N-1:0]      in_empty = '0;
  logic [N*CHW-1:0]  in_chan = '0;
  logic [N*ERW-1:0]  in_err = '0;
  logic              out_valid, out_ready = 1'b1;
  logic [DW-1:0]     out_data;
  logic              out_sop, out_eop;
  logic [0:0]        out_empty;
  logic [OCW-1:0]    out_chan;
  logic [ERW-1:0]    out_err;

  int checks = 0, fails = 0;
  beat_t srcq[N][$];
  beat_t sb[$];
  int    got_src[$];
  logic [N-1:0] pop_pend = '0;
  logic [7:0]   rdy_pat = 8'hFF;
  int    cyc = 0, seq = 0;
  logic  stall_prev = 1'b0;
  logic [DW-1:0] s_data;
  logic [OCW-1:0] s_chan;
  logic s_sop, s_eop, s_empty;
  logic [ERW-1:0] s_err;

  always #2 clk = ~clk;

  rr_quantum_merge #(.N_IN(N), .SYM_BITS(8), .SYMS(2), .CH_W(CHW), .ERR_W(ERW),
                     .QUANTUM(2), .PKT_EN(1'b1), .PKT_SCHED(1'b1), .TAG_SRC(1'b1))
  i_rr_quantum_merge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_chan(in_chan),
    .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty), .out_chan(out_chan),
    .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one packet of len beats on input i
  task automatic add_pkt(input int i, input int len, input int gap_first, input int gap_mid);
    for (int n = 0; n < len; n++) begin
      beat_t b;
      b.src   = i;
      b.data  = 16'(i * 4096 + seq * 37 + 5);
      b.sop   = (n == 0);
      b.eop   = (n == len - 1);
      b.empty = seq[0];
      b.ch    = 3'(seq + i);
      b.err   = 2'(seq);
      b.gap   = (n == 0) ? gap_first : gap_mid;
      seq++;
      srcq[i].push_back(b);
    end
  endtask

  // per-cycle driver and monitor
  always @(negedge clk) begin
    if (rst) begin
      in_valid = '0;
      pop_pend = '0;
      stall_prev = 1'b0;
    end else begin
      for (int i = 0; i < N; i++)
        if (pop_pend[i]) begin void'(srcq[i].pop_front()); pop_pend[i] = 1'b0; end
      for (int i = 0; i < N; i++) begin
        if (srcq[i].size() > 0 && srcq[i][0].gap == 0) begin
          in_valid[i]            = 1'b1;
          in_data[i*DW +: DW]    = srcq[i][0].data;
          in_sop[i]              = srcq[i][0].sop;
          in_eop[i]              = srcq[i][0].eop;
          in_empty[i]            = srcq[i][0].empty;
          in_chan[i*CHW +: CHW]  = srcq[i][0].ch;
          in_err[i*ERW +: ERW]   = srcq[i][0].err;
        end else begin
          in_valid[i] = 1'b0;
          if (srcq[i].size() > 0) srcq[i][0].gap = srcq[i][0].gap - 1;
        end
      end
      out_ready = rdy_pat[cyc % 8];
      cyc++;
      #1;
      chk($countones(in_ready) <= 1, "R7", "ready count", $countones(in_ready), 1);
      if (stall_prev) begin
        chk(out_valid && out_data == s_data && out_chan == s_chan && out_sop == s_sop &&
            out_eop == s_eop && out_empty == s_empty && out_err == s_err,
            "R8", "stalled beat held", out_data, s_data);
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected beat", out_data, 0);
        end else begin
          beat_t e;
          e = sb.pop_front();
          got_src.push_back(int'(out_chan[4:3]));
          chk(out_data == e.data, "R5", "data", out_data, e.data);
          chk(out_sop == e.sop && out_eop == e.eop, "R5", "sop/eop",
              {out_sop, out_eop}, {e.sop, e.eop});
          chk(out_empty == e.empty && out_err == e.err, "R5", "empty/err",
              {out_empty, out_err}, {e.empty, e.err});
          chk(out_chan == {2'(e.src), e.ch}, "R6", "tagged channel", out_chan,
              {2'(e.src), e.ch});
        end
      end
      for (int i = 0; i < N; i++) begin
        if (in_valid[i] && in_ready[i]) begin
          chk(in_ready[i] == (out_ready || !out_valid), "R7", "ready level",
              in_ready[i], out_ready || !out_valid);
          sb.push_back(srcq[i][0]);
          pop_pend[i] = 1'b1;
        end
      end
      stall_prev = out_valid && !out_ready;
      s_data = out_data; s_chan = out_chan; s_sop = out_sop;
      s_eop = out_eop; s_empty = out_empty; s_err = out_err;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < N; i++) srcq[i].delete();
    sb.delete();
    got_src.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain();
    while (srcq[0].size() + srcq[1].size() + srcq[2].size() + sb.size() > 0 || pop_pend != 0)
      @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_order(input int exp[$], input string req);
    chk(got_src.size() == exp.size(), req, "beat count", got_src.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got_src.size(); k++)
      chk(got_src[k] == exp[k], req, $sformatf("source of beat %0d", k), got_src[k], exp[k]);
  endtask

  task automatic run_all();
    // R1: reset state
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 3'b001, "R1", "ready after reset", in_ready, 1);

    // R2: one-beat packets, all inputs busy, quantum of two
    do_reset();
    for (int p = 0; p < 4; p++) for (int i = 0; i < N; i++) add_pkt(i, 1, 0, 0);
    drain();
    check_order('{0,0,1,1,2,2,0,0,1,1,2,2}, "R2");

    // R4: three-beat packets overrun the quantum until end-of-packet
    do_reset();
    for (int p = 0; p < 2; p++) for (int i = 0; i < N; i++) add_pkt(i, 3, 0, 0);
    drain();
    check_order('{0,0,0,1,1,1,2,2,2,0,0,0,1,1,1,2,2,2}, "R4");

    // R3: only input 2 has traffic, grant starts at 0 and skips
    do_reset();
    for (int p = 0; p < 4; p++) add_pkt(2, 1, 0, 0);
    drain();
    check_order('{2,2,2,2}, "R3");

    // R4: input 0 pauses mid-packet while input 1 waits
    do_reset();
    add_pkt(0, 2, 0, 3);
    add_pkt(1, 1, 0, 0);
    drain();
    check_order('{0,0,1}, "R4");

    // R8 and R5: irregular backpressure, quantum counts accepted beats only
    do_reset();
    rdy_pat = 8'b1011_0110;
    for (int p = 0; p < 2; p++) for (int i = 0; i < N; i++) add_pkt(i, 3, 0, 1);
    drain();
    check_order('{0,0,0,1,1,1,2,2,2,0,0,0,1,1,1,2,2,2}, "R8");
    rdy_pat = 8'hFF;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule